// File: doc/BRIEF.md
# Two-Step Converter Bus Sequencer

This block is the digital timing and control logic of an 8-bit two-step (coarse pass, then fine pass) converter, seen from a host bus. Each comparator pass appears as a 15-bit thermometer vector, and the block encodes it to a 4-bit nibble. The coarse nibble becomes the upper half of the result and the fine nibble the lower half. The block holds the result in an output latch and drives an 8-bit data bus that has an output enable, an active-low end-of-conversion interrupt and a ready status line. All analog delays are counted in clock cycles.

A mode input selects the bus protocol. With mode low, a falling read strobe starts a conversion and the ready line can hold the host in a wait state until the data is valid. With mode high, a write pulse starts the conversion. The host then either waits for the interrupt or reads early, which cuts the fine pass short. Tying write and read together gives pipelined operation: one strobe starts a new conversion and presents the previous result. A power-down input stops all activity. After wake-up, strobes are ignored until a set number of cycles has passed.

All bus inputs are sampled on the clock. An input edge is taken as seen at the first clock edge where the new level is present.

Top module: `hfadc_seq`

## Requirements
- R1: Each thermometer vector encodes to a nibble equal to one plus the index of its highest set bit, or 0 when no bit is set. The coarse nibble is result bits 7:4 and the fine nibble is result bits 3:0.
- R2: While `cs_n` is high, falling and rising edges of `rd_n` and `wr_n` start nothing and complete nothing.
- R3: With `mode_i` low, a falling `rd_n` edge starts a conversion and samples the coarse vector at that edge. CONV_CYC cycles later the fine vector is sampled, the full byte is loaded into the result latch, and `irq_n` goes low.
- R4: With `mode_i` low, `rdy_o` goes low the cycle after a falling `cs_n` edge. It returns high when a conversion completes or on a rising `cs_n` edge.
- R5: `irq_n` returns high the cycle after a rising `rd_n` edge (with `cs_n` low) or a rising `cs_n` edge. A conversion that completes in the same cycle takes priority.
- R6: With `mode_i` high, a `wr_n` low pulse starts a conversion. At the rising `wr_n` edge the coarse nibble is written into result bits 7:4. FINE_CYC cycles after that edge the fine nibble is written into bits 3:0 and `irq_n` goes low.
- R7: A falling `rd_n` edge while the fine pass is still waiting writes the fine nibble sampled at that edge at once, and `irq_n` goes low the next cycle. The timer expiry then causes no further change.
- R8: With `wr_n` and `rd_n` driven together in mode high, each low strobe presents the previous result on the bus while it starts the next conversion.
- R9: `dout_oe` is high exactly when `cs_n` and `rd_n` are both low and the block is awake. `dout` then shows the result latch.
- R10: A low `pd_n` aborts any conversion and holds `irq_n` and `rdy_o` high and `dout_oe` low. Once `pd_n` is seen high, strobe edges are ignored during the first WAKE_CYC-1 cycles.
- R11: After reset `irq_n` and `rdy_o` are high, `dout_oe` is low and the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mode_i | input | 1 | 0: read-started mode, 1: write-read mode |
| pd_n | input | 1 | Power-down, low shuts the block down |
| coarse_therm | input | 15 | Coarse pass thermometer vector |
| fine_therm | input | 15 | Fine pass thermometer vector |
| dout | output | 8 | Result latch value |
| dout_oe | output | 1 | Data bus drive enable (low means high-impedance) |
| irq_n | output | 1 | End-of-conversion interrupt, active low |
| rdy_o | output | 1 | Ready status, low while the host must wait (open-drain pull-down modelled as 0) |

## Verification
The assertions check four things on every cycle: a rising interrupt always has a clearing edge or a power-down behind it; an idle block with chip select high stays idle; both the counted end of a read-started conversion and an early read drop the interrupt on the next cycle; and power-down leaves every output inactive. The bench's scenarios are needed for the rest: that the coarse nibble is taken at the start or write-rise edge and not later, the exact byte values from the encoders, the previous-result ordering of the tied-strobe protocol, and the wake-up window during which strobes do nothing.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RCONV  = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_FINE   = 2'd3
    } phase_e;

endpackage

// File: rtl/hfadc_therm_enc.sv
module hfadc_therm_enc #(
    parameter int OUT_W = 4,
    localparam int IN_W = (1 << OUT_W) - 1
) (
    input  logic [IN_W-1:0]  therm,
    output logic [OUT_W-1:0] nib
);

    // highest set bit wins, so a stray low bubble does not corrupt the code
    always_comb begin
        nib = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (therm[i]) nib = OUT_W'(i + 1);
        end
    end

endmodule

// File: rtl/hfadc_wake.sv
module hfadc_wake #(
    parameter int WAKE_CYC = 20,
    localparam int WCW = $clog2(WAKE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    output logic awake_o
);

    typedef struct packed {
        logic           awake;
        logic [WCW-1:0] cnt;
    } wake_t;

    wake_t wk_d, wk_q;

    always_comb begin
        wk_d = wk_q;
        if (!pd_n) begin
            wk_d.awake = 1'b0;
            wk_d.cnt   = WCW'(WAKE_CYC);
        end else if (!wk_q.awake) begin
            if (wk_q.cnt <= WCW'(1)) wk_d.awake = 1'b1;
            else                     wk_d.cnt   = wk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q.awake <= 1'b1;
            wk_q.cnt   <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign awake_o = wk_q.awake;

    // R10: the block is never awake in the cycle after a low power-down input
    a_r10_sleep_clears_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> !awake_o);

endmodule

// File: rtl/hfadc_strobe_edge.sv
module hfadc_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic awake,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic cs_fall,
    output logic cs_rise,
    output logic rd_fall,
    output logic rd_rise,
    output logic wr_fall,
    output logic wr_rise
);

    typedef struct packed {
        logic cs;
        logic rd;
        logic wr;
    } prev_t;

    prev_t pv_d, pv_q;

    always_comb begin
        pv_d.cs = cs_n;
        pv_d.rd = rd_n;
        pv_d.wr = wr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv_q <= '1;
        else        pv_q <= pv_d;
    end

    // strobe edges only count while selected and awake
    assign cs_fall = awake &  pv_q.cs & ~cs_n;
    assign cs_rise = awake & ~pv_q.cs &  cs_n;
    assign rd_fall = awake & ~cs_n &  pv_q.rd & ~rd_n;
    assign rd_rise = awake & ~cs_n & ~pv_q.rd &  rd_n;
    assign wr_fall = awake & ~cs_n &  pv_q.wr & ~wr_n;
    assign wr_rise = awake & ~cs_n & ~pv_q.wr &  wr_n;

endmodule

// File: rtl/hfadc_seq.sv
module hfadc_seq
    import hfadc_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int CONV_CYC = 70,
    parameter int FINE_CYC = 38,
    parameter int WAKE_CYC = 20,
    localparam int THERM_W = (1 << NIB_W) - 1,
    localparam int DATA_W  = 2 * NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               mode_i,
    input  logic               pd_n,
    input  logic [THERM_W-1:0] coarse_therm,
    input  logic [THERM_W-1:0] fine_therm,
    output logic [DATA_W-1:0]  dout,
    output logic               dout_oe,
    output logic               irq_n,
    output logic               rdy_o
);

    localparam int MAX_CYC = (CONV_CYC > FINE_CYC) ? CONV_CYC : FINE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam int N_PASS  = 2;

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [NIB_W-1:0]  hi;
        logic [DATA_W-1:0] res;
        logic              irq_n;
        logic              rdy_low;
    } core_t;

    core_t q, d;

    logic awake;
    logic cs_fall, cs_rise, rd_fall, rd_rise, wr_fall, wr_rise;
    logic [THERM_W-1:0] therm_arr [N_PASS];
    logic [NIB_W-1:0]   nib_arr   [N_PASS];
    logic [NIB_W-1:0]   coarse_nib, fine_nib;

    assign therm_arr[0] = coarse_therm;
    assign therm_arr[1] = fine_therm;

    for (genvar p = 0; p < N_PASS; p++) begin : g_pass
        hfadc_therm_enc #(.OUT_W(NIB_W)) i_enc (
            .therm (therm_arr[p]),
            .nib   (nib_arr[p])
        );
    end

    assign coarse_nib = nib_arr[0];
    assign fine_nib   = nib_arr[1];

    hfadc_wake #(.WAKE_CYC(WAKE_CYC)) i_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .awake_o (awake)
    );

    hfadc_strobe_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .awake   (awake),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise),
        .rd_fall (rd_fall),
        .rd_rise (rd_rise),
        .wr_fall (wr_fall),
        .wr_rise (wr_rise)
    );

    always_comb begin
        d = q;
        if (!pd_n) begin
            d.phase   = PH_IDLE;
            d.cnt     = '0;
            d.irq_n   = 1'b1;
            d.rdy_low = 1'b0;
        end else begin
            if (cs_rise || rd_rise) d.irq_n = 1'b1;
            if (cs_fall && !mode_i) d.rdy_low = 1'b1;
            if (cs_rise)            d.rdy_low = 1'b0;

            // completion of the pass in flight
            unique case (q.phase)
                PH_RCONV: begin
                    if (q.cnt == CW'(1)) begin
                        d.res     = {q.hi, fine_nib};
                        d.irq_n   = 1'b0;
                        d.rdy_low = 1'b0;
                        d.phase   = PH_IDLE;
                        d.cnt     = '0;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                PH_FINE: begin
                    if (rd_fall || q.cnt == CW'(1)) begin
                        d.res[NIB_W-1:0] = fine_nib;
                        d.irq_n          = 1'b0;
                        d.phase          = PH_IDLE;
                        d.cnt            = '0;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                default: ;
            endcase

            // new activity, decided on the phase held before this edge
            if (wr_fall && mode_i) begin
                d.phase = PH_SAMPLE;
                d.cnt   = '0;
            end else if (rd_fall && !mode_i && q.phase == PH_IDLE) begin
                d.phase = PH_RCONV;
                d.cnt   = CW'(CONV_CYC);
                d.hi    = coarse_nib;
            end else if (wr_rise && q.phase == PH_SAMPLE) begin
                d.phase               = PH_FINE;
                d.cnt                 = CW'(FINE_CYC);
                d.res[DATA_W-1:NIB_W] = coarse_nib;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase   <= PH_IDLE;
            q.cnt     <= '0;
            q.hi      <= '0;
            q.res     <= '0;
            q.irq_n   <= 1'b1;
            q.rdy_low <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dout    = q.res;
    assign dout_oe = ~cs_n & ~rd_n & awake;
    assign irq_n   = q.irq_n;
    assign rdy_o   = ~q.rdy_low;

    // R5: the interrupt only releases after a clearing edge or a power-down
    a_r5_irq_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(cs_rise || rd_rise || !pd_n));

    // R2: an idle block with chip select high stays idle
    a_r2_deselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && q.phase == PH_IDLE) |=> (q.phase == PH_IDLE));

    // R3, R4: counted end of a read-started conversion
    a_r3_read_conv_end: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RCONV && q.cnt == CW'(1) && pd_n) |=> (!irq_n && rdy_o));

    // R7: an early read ends the fine pass on the next cycle
    a_r7_early_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_FINE && rd_fall && pd_n && !(wr_fall && mode_i))
            |=> (!irq_n && q.phase == PH_IDLE));

    // R10: power-down leaves every output inactive
    a_r10_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (q.phase == PH_IDLE && irq_n && rdy_o && !dout_oe));

endmodule

// File: tb/test_hfadc_seq.sv
module test_hfadc_seq;

    localparam int CONV = 70;
    localparam int FINE = 38;
    localparam int WAKE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode_i = 1'b0, pd_n = 1'b1;
    logic [14:0] coarse_therm = '0, fine_therm = '0;
    logic [7:0]  dout;
    logic        dout_oe, irq_n, rdy_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    hfadc_seq #(.NIB_W(4), .CONV_CYC(CONV), .FINE_CYC(FINE), .WAKE_CYC(WAKE)) i_hfadc_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .mode_i(mode_i), .pd_n(pd_n), .coarse_therm(coarse_therm), .fine_therm(fine_therm),
        .dout(dout), .dout_oe(dout_oe), .irq_n(irq_n), .rdy_o(rdy_o)
    );

    function automatic int enc(input logic [14:0] v);
        int r = 0;
        for (int i = 0; i < 15; i++) if (v[i]) r = i + 1;
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // behavioural reference: phase 0 idle, 1 read conv, 2 write low, 3 fine wait
    int   m_phase, m_cnt, m_wake, m_hi, m_res;
    bit   m_irq, m_rdylow, m_awake, m_started;
    bit   p_cs, p_rd, p_wr;
    bit   csf, csr, rdf, rdr, wrf, wrr, a;
    int   old, fn, cn;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_wake = 0; m_hi = 0; m_res = 0;
            m_irq = 1; m_rdylow = 0; m_awake = 1; m_started = 0;
            p_cs = 1; p_rd = 1; p_wr = 1;
        end else begin
            a   = m_awake;
            csf = a && p_cs && !cs_n;
            csr = a && !p_cs && cs_n;
            rdf = a && !cs_n && p_rd && !rd_n;
            rdr = a && !cs_n && !p_rd && rd_n;
            wrf = a && !cs_n && p_wr && !wr_n;
            wrr = a && !cs_n && !p_wr && wr_n;
            fn  = enc(fine_therm);
            cn  = enc(coarse_therm);
            if (!pd_n) begin
                m_phase = 0; m_irq = 1; m_rdylow = 0; m_awake = 0; m_wake = WAKE;
            end else begin
                if (csr || rdr) m_irq = 1;
                if (csf && !mode_i) m_rdylow = 1;
                if (csr) m_rdylow = 0;
                old = m_phase;
                if (old == 1) begin
                    if (m_cnt == 1) begin
                        m_res = m_hi * 16 + fn; m_irq = 0; m_rdylow = 0; m_phase = 0;
                    end else m_cnt--;
                end else if (old == 3) begin
                    if (rdf || m_cnt == 1) begin
                        m_res = (m_res & 8'hF0) | fn; m_irq = 0; m_phase = 0;
                    end else m_cnt--;
                end
                if (wrf && mode_i) m_phase = 2;
                else if (rdf && !mode_i && old == 0) begin
                    m_phase = 1; m_cnt = CONV; m_hi = cn;
                end else if (wrr && old == 2) begin
                    m_phase = 3; m_cnt = FINE; m_res = (m_res & 8'h0F) | (cn * 16);
                end
                if (!m_awake) begin
                    if (m_wake <= 1) m_awake = 1;
                    else m_wake--;
                end
            end
            p_cs = cs_n; p_rd = rd_n; p_wr = wr_n;
            m_started = 1;
        end
    end

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && m_started) begin
            chk("R5 irq_n vs model", int'(irq_n), int'(m_irq));
            chk("R4 rdy_o vs model", int'(rdy_o), int'(!m_rdylow));
            chk("R9 dout_oe vs model", int'(dout_oe), int'(!cs_n && !rd_n && m_awake));
            if (dout_oe) chk("R1 dout vs model", int'(dout), m_res);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog R11: actual %0d cycles expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R11 reset irq_n", int'(irq_n), 1);
        chk("R11 reset rdy_o", int'(rdy_o), 1);
        chk("R11 reset dout_oe", int'(dout_oe), 0);
        rst_n = 1'b1;
        tick(3);

        // read-started conversion, coarse taken at start, bubble in fine vector
        mode_i = 1'b0; coarse_therm = 15'h007F; fine_therm = 15'h0105;
        cs_n = 1'b0; tick(1);
        chk("R4 rdy low after select", int'(rdy_o), 0);
        rd_n = 1'b0; tick(1);
        coarse_therm = 15'h7FFF;
        tick(CONV - 1);
        chk("R3 irq still high before end", int'(irq_n), 1);
        chk("R4 rdy still low before end", int'(rdy_o), 0);
        tick(1);
        chk("R3 irq low at end", int'(irq_n), 0);
        chk("R4 rdy released at end", int'(rdy_o), 1);
        chk("R9 bus driven", int'(dout_oe), 1);
        chk("R1 R3 result byte", int'(dout), 8'h79);
        rd_n = 1'b1; tick(1);
        chk("R5 irq released by read rise", int'(irq_n), 1);
        chk("R9 bus released", int'(dout_oe), 0);
        cs_n = 1'b1; tick(2);

        // strobes with chip select high
        rd_n = 1'b0; tick(CONV + 3);
        chk("R2 no conversion when deselected", int'(irq_n), 1);
        chk("R2 bus idle when deselected", int'(dout_oe), 0);
        rd_n = 1'b1; mode_i = 1'b1;
        wr_n = 1'b0; tick(2); wr_n = 1'b1; tick(FINE + 3);
        chk("R2 write ignored when deselected", int'(irq_n), 1);

        // write-read mode using the internal delay
        coarse_therm = 15'h00FF; fine_therm = 15'h000F;
        cs_n = 1'b0; tick(1);
        chk("R4 rdy unused in write-read mode", int'(rdy_o), 1);
        wr_n = 1'b0; tick(2);
        wr_n = 1'b1; tick(1);
        coarse_therm = 15'h0000;
        tick(FINE - 1);
        chk("R6 irq high before delay", int'(irq_n), 1);
        tick(1);
        chk("R6 irq low after delay", int'(irq_n), 0);
        rd_n = 1'b0; tick(1);
        chk("R6 result byte", int'(dout), 8'h84);
        rd_n = 1'b1; tick(1);
        chk("R5 irq released", int'(irq_n), 1);

        // early read cuts the fine pass short
        coarse_therm = 15'h0007; fine_therm = 15'h0000;
        wr_n = 1'b0; tick(2);
        wr_n = 1'b1; tick(1);
        tick(5);
        fine_therm = 15'h003F;
        rd_n = 1'b0; tick(1);
        chk("R7 irq low after early read", int'(irq_n), 0);
        chk("R7 early result", int'(dout), 8'h36);
        fine_therm = 15'h7FFF;
        tick(FINE);
        chk("R7 no change at timer expiry", int'(dout), 8'h36);
        chk("R7 irq stays low", int'(irq_n), 0);
        rd_n = 1'b1; tick(1);
        chk("R5 irq released after early read", int'(irq_n), 1);

        // tied strobes: previous result shown while the next one starts
        coarse_therm = 15'h03FF; fine_therm = 15'h001F;
        wr_n = 1'b0; rd_n = 1'b0; tick(1);
        chk("R8 first strobe shows old result", int'(dout), 8'h36);
        tick(1);
        wr_n = 1'b1; rd_n = 1'b1; tick(FINE + 2);
        chk("R8 irq low after pipelined pass", int'(irq_n), 0);
        coarse_therm = 15'h0001; fine_therm = 15'h0000;
        wr_n = 1'b0; rd_n = 1'b0; tick(1);
        chk("R8 second strobe shows first result", int'(dout), 8'hA5);
        tick(1);
        wr_n = 1'b1; rd_n = 1'b1; tick(FINE + 2);
        wr_n = 1'b0; rd_n = 1'b0; tick(1);
        chk("R8 third strobe shows second result", int'(dout), 8'h10);
        tick(1);
        wr_n = 1'b1; rd_n = 1'b1; tick(FINE + 2);

        // power-down aborts a fine pass
        wr_n = 1'b0; tick(2); wr_n = 1'b1; tick(3);
        cs_n = 1'b1; tick(1);
        pd_n = 1'b0; tick(1);
        chk("R10 irq high in power-down", int'(irq_n), 1);
        chk("R10 rdy high in power-down", int'(rdy_o), 1);
        tick(FINE + 2);
        chk("R10 aborted pass gives no interrupt", int'(irq_n), 1);

        // wake-up window ignores a read strobe
        mode_i = 1'b0; coarse_therm = 15'h0000; fine_therm = 15'h7FFF;
        pd_n = 1'b1; cs_n = 1'b0; rd_n = 1'b0; tick(1);
        tick(CONV + 2);
        chk("R10 strobe during wake ignored", int'(irq_n), 1);
        rd_n = 1'b1; tick(WAKE + 2);
        rd_n = 1'b0; tick(1);
        tick(CONV);
        chk("R10 conversion after wake", int'(irq_n), 0);
        chk("R1 empty coarse full fine", int'(dout), 8'h0F);
        rd_n = 1'b1; cs_n = 1'b1; tick(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule